// File: doc/BRIEF.md
# Block Burst Interval Pacer

This block spaces out the bursts of a single DMA channel. It raises a block-ready level for the channel's burst engine. The level is cleared when a block finishes. It is raised again once a programmed 16-bit interval has elapsed. The interval is counted in units of a prescaled clock, and the prescaler divides the system clock by 1, 4, 16 or 64.

When the channel is switched on, the first block may go at once. Each block-done pulse restarts the wait, including the prescaler phase, so every gap is measured from the completion of the block that caused it. The pacing continues block after block until the channel is switched off. Switching the channel off clears all timing state and drops the ready level. Arbitration between channels and address stepping are handled elsewhere.

Top module: `bpt_block_pacer`

## Requirements
- R1: After reset, `block_ready` is 0.
- R2: When `chan_active` is 0 at a rising edge, `block_ready` is 0 after that edge and any wait in progress is discarded. A later reactivation does not wait out the old interval.
- R3: When `chan_active` is 1 and no wait is in progress, `block_ready` is 1 after the next rising edge. This lets the first block after activation go without delay.
- R4: A `block_done` pulse sampled high while active, with `interval` = N > 0, makes `block_ready` 0 after that edge. `block_ready` then stays 0 for exactly N × D clock cycles and returns to 1. D is the divide ratio set by R5.
- R5: `prescale_sel` selects D as follows: 0 gives 1, 1 gives 4, 2 gives 16 and 3 gives 64.
- R6: A `block_done` pulse with `interval` = 0 leaves `block_ready` at 1, so no wait is inserted.
- R7: `interval` and `prescale_sel` are captured only in the cycle of `block_done`. Changing them during a wait does not change the length of that wait.
- R8: A `block_done` pulse that arrives during a wait restarts the wait from that pulse. The restarted wait uses the values captured with that pulse, and the prescaler phase restarts at zero.
- R9: Once `block_ready` is 1, it stays 1 until `block_done` arrives or `chan_active` drops.
- R10: The pacing repeats. Every block-done pulse in a run of consecutive blocks yields the same wait for the same settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_active | input | 1 | Channel enabled and transfer not yet finished |
| block_done | input | 1 | One-cycle pulse marking the end of a block burst |
| interval | input | 16 | Gap between blocks, in prescaled ticks |
| prescale_sel | input | 2 | Prescaler select (0 to 3 gives divide by 1, 4, 16, 64) |
| block_ready | output | 1 | Level that allows the next block burst to start |

## Verification
The properties take four things for granted about the inputs. Reset is synchronous. Inputs settle between clock edges. `block_done` is a single-cycle pulse. `interval` and `prescale_sel` are valid in the cycle where that pulse is high. The bench meets these conditions by driving every input on the falling clock edge and raising `block_done` for exactly one cycle, together with the settings for that block. The wait lengths are swept over all four prescaler settings and a range of intervals. Each measured low time is compared with N × 4^sel, computed in the bench.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_READY = 2'd1,
    PS_WAIT  = 2'd2
  } pace_state_e;

  // divide ratio: each select step multiplies the divisor by 2**step_log2
  function automatic int unsigned div_ratio(input int unsigned sel,
                                            input int unsigned step_log2);
    return 32'd1 << (sel * step_log2);
  endfunction

  // width of a counter that must reach the largest divisor minus one
  function automatic int unsigned pre_width(input int unsigned sel_w,
                                            input int unsigned step_log2);
    int unsigned w;
    w = step_log2 * ((32'd1 << sel_w) - 1);
    return (w == 0) ? 1 : w;
  endfunction

endpackage

// File: rtl/bpt_prescaler.sv
module bpt_prescaler
  import bpt_pkg::*;
#(
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned STEP_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [SEL_W-1:0] sel_in,
  output logic             tick
);
  localparam int unsigned PRE_W = pre_width(SEL_W, STEP_LOG2);

  logic [SEL_W-1:0] sel_q;
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] term;

  always_comb begin
    term = PRE_W'(div_ratio(int'(sel_q), STEP_LOG2) - 1);
    tick = run && (cnt_q == term);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      sel_q <= sel_in;
    end else if (run) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/bpt_interval_cnt.sv
module bpt_interval_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             expire
);
  logic [CNT_W-1:0] rem_q;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  assign expire = step && (rem_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      rem_q <= '0;
    else if (clear)  rem_q <= '0;
    else if (load)   rem_q <= load_val;
    else if (step)   rem_q <= rem_q - 1'b1;
  end
endmodule

// File: rtl/bpt_pace_ctrl.sv
module bpt_pace_ctrl
  import bpt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic done,
  input  logic interval_zero,
  input  logic expire,
  output logic ready,
  output logic waiting
);
  pace_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!active)            state_d = PS_IDLE;
    else if (done)          state_d = interval_zero ? PS_READY : PS_WAIT;
    else begin
      unique case (state_q)
        PS_IDLE:  state_d = PS_READY;
        PS_WAIT:  state_d = expire ? PS_READY : PS_WAIT;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PS_IDLE;
    else        state_q <= state_d;
  end

  assign ready   = (state_q == PS_READY);
  assign waiting = (state_q == PS_WAIT);
endmodule

// File: rtl/bpt_block_pacer.sv
module bpt_block_pacer #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned STEP_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_active,
  input  logic             block_done,
  input  logic [CNT_W-1:0] interval,
  input  logic [SEL_W-1:0] prescale_sel,
  output logic             block_ready
);
  logic restart;
  logic waiting;
  logic run;
  logic pre_tick;
  logic expire;
  logic interval_zero;

  assign restart       = chan_active && block_done;
  assign run           = waiting && chan_active && !block_done;
  assign interval_zero = (interval == '0);

  bpt_prescaler #(.SEL_W(SEL_W), .STEP_LOG2(STEP_LOG2)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(restart),
    .run    (run),
    .sel_in (prescale_sel),
    .tick   (pre_tick)
  );

  bpt_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (!chan_active),
    .load    (restart),
    .load_val(interval),
    .step    (pre_tick),
    .expire  (expire)
  );

  bpt_pace_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .active       (chan_active),
    .done         (block_done),
    .interval_zero(interval_zero),
    .expire       (expire),
    .ready        (block_ready),
    .waiting      (waiting)
  );
endmodule

// File: rtl/bpt_pacer_chk.sv
module bpt_pacer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_active,
  input logic             block_done,
  input logic [CNT_W-1:0] interval,
  input logic             block_ready,
  input logic             waiting,
  input logic             pre_tick,
  input logic             expire
);
  AST_INACTIVE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_active |=> !block_ready); // R2
  AST_FIRST_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    chan_active && !block_done && !waiting |=> block_ready); // R3
  AST_DONE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    chan_active && block_done && (interval != '0) |=> !block_ready && waiting); // R4
  AST_EXPIRE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    expire && chan_active && !block_done |=> block_ready); // R4
  AST_TICK_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |-> waiting); // R5
  AST_ZERO_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    chan_active && block_done && (interval == '0) |=> block_ready); // R6
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    block_ready && chan_active && !block_done |=> block_ready); // R9
endmodule

bind bpt_block_pacer bpt_pacer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chan_active(chan_active),
  .block_done (block_done),
  .interval   (interval),
  .block_ready(block_ready),
  .waiting    (waiting),
  .pre_tick   (pre_tick),
  .expire     (expire)
);

// File: tb/sim_bpt_block_pacer.sv
`timescale 1ns/1ps
module sim_bpt_block_pacer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        chan_active;
  logic        block_done;
  logic [15:0] interval;
  logic [1:0]  prescale_sel;
  logic        block_ready;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  bpt_block_pacer u0 (
    .clk(clk), .rst_n(rst_n), .chan_active(chan_active), .block_done(block_done),
    .interval(interval), .prescale_sel(prescale_sel), .block_ready(block_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_low(input int n, input int s);
    int d = 1;
    for (int k = 0; k < s; k++) d = d * 4;
    return n * d;
  endfunction

  // pulse block_done with settings, count cycles with ready low afterwards
  task automatic run_block(input int n, input int s, input bit disturb, output int lows);
    @(negedge clk);
    block_done = 1'b1; interval = 16'(n); prescale_sel = 2'(s);
    @(negedge clk);
    block_done = 1'b0;
    lows = 0;
    while (!block_ready && lows < 30000) begin
      lows++;
      if (disturb && lows == 2) begin
        interval = ~16'(n);
        prescale_sel = 2'(s) ^ 2'd1;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lows;
    rst_n = 1'b0; chan_active = 1'b0; block_done = 1'b0;
    interval = '0; prescale_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(block_ready == 1'b0, "R1 reset ready", block_ready, 0);

    chan_active = 1'b1;
    @(negedge clk);
    chk(block_ready == 1'b1, "R3 first block immediate", block_ready, 1);

    // R4 R5: near-exhaustive sweep of small intervals over all prescalers
    for (int s = 0; s < 4; s++)
      for (int n = 1; n <= 8; n++) begin
        run_block(n, s, 1'b0, lows);
        chk(lows == expect_low(n, s), $sformatf("R4/R5 n=%0d sel=%0d", n, s),
            lows, expect_low(n, s));
      end
    run_block(300, 3, 1'b0, lows);
    chk(lows == expect_low(300, 3), "R4 long interval", lows, expect_low(300, 3));

    // R6 zero interval
    run_block(0, 3, 1'b0, lows);
    chk(lows == 0, "R6 zero interval no wait", lows, 0);

    // R7 settings changed mid-wait
    for (int s = 0; s < 4; s++) begin
      run_block(5, s, 1'b1, lows);
      chk(lows == expect_low(5, s), "R7 captured settings", lows, expect_low(5, s));
    end

    // R8 restart during wait
    @(negedge clk);
    block_done = 1'b1; interval = 16'd10; prescale_sel = 2'd1;
    @(negedge clk);
    block_done = 1'b0;
    repeat (15) @(negedge clk);
    chk(block_ready == 1'b0, "R8 still waiting", block_ready, 0);
    run_block(3, 0, 1'b0, lows);
    chk(lows == 3, "R8 restart from new pulse", lows, 3);
    @(negedge clk);
    block_done = 1'b1; interval = 16'd2; prescale_sel = 2'd2;
    @(negedge clk);
    block_done = 1'b0;
    repeat (7) @(negedge clk);
    run_block(1, 2, 1'b0, lows);
    chk(lows == 16, "R8 prescaler phase restarts", lows, 16);

    // R9 ready holds
    begin
      int drops = 0;
      repeat (50) begin
        @(negedge clk);
        if (!block_ready) drops++;
      end
      chk(drops == 0, "R9 ready holds while idle", drops, 0);
    end

    // R10 repeated blocks
    for (int b = 0; b < 5; b++) begin
      run_block(6, 1, 1'b0, lows);
      chk(lows == 24, $sformatf("R10 block %0d", b), lows, 24);
    end

    // R2 deactivate during wait, then reactivate
    @(negedge clk);
    block_done = 1'b1; interval = 16'd100; prescale_sel = 2'd3;
    @(negedge clk);
    block_done = 1'b0;
    repeat (4) @(negedge clk);
    chan_active = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(block_ready == 1'b0, "R2 inactive ready low", block_ready, 0);
    end
    chan_active = 1'b1;
    @(negedge clk);
    chk(block_ready == 1'b1, "R2 wait discarded on reactivation", block_ready, 1);
    chan_active = 1'b0;
    @(negedge clk);
    chk(block_ready == 1'b0, "R2 drop from ready", block_ready, 0);
    chan_active = 1'b1;
    @(negedge clk);
    chk(block_ready == 1'b1, "R3 reactivation immediate", block_ready, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule